// File: doc/BRIEF.md
# Byte-Addressed Register Bank with Atomic Wide-Parameter Commit

This block is a small bank of 8-bit control registers that sits behind a byte-level serial-bus front end. The front end (not part of this block) turns line activity into single-cycle strobes: transaction start, transaction stop, a received byte to write, and a byte to be read. Inside a transaction, the first written byte sets an address pointer. Every later byte then reads or writes the register that the pointer selects, and the pointer steps forward by one after each access.

Some configuration values are wider than one byte and occupy consecutive addresses, most significant byte at the lowest address. Writes to the lower addresses of such a value only fill a private staging buffer. The exported value changes in a single cycle, and only when the final byte is written right after the earlier bytes, in ascending order. Logic that consumes the exported values therefore never sees a mix of old and new bytes.

Address map: 0x00 holds an 8-bit read/write control byte. 0x01 is a read-only status byte. 0x02 and 0x03 hold a 12-bit value, committed on the write to 0x03. 0x04 to 0x06 hold a 24-bit value, committed on the write to 0x06. 0x07 is a write-only key byte. All other addresses are unmapped.

Top module: `regbank_atomic`

## Requirements
- R1: Inside a transaction opened by `bus_start`, the first `byte_wr` strobe loads `wdata` into the address pointer and writes no register.
- R2: Each later `byte_wr` or `byte_rd` accesses the register at the pointer, then adds one to the pointer, wrapping from 0xFF to 0x00.
- R3: Address 0x00 is read/write. A write appears on `cfg_ctrl` one cycle after the strobe, and a read returns the stored byte. Reset value is 0x00.
- R4: Address 0x01 is read-only. A read returns `stat_in`, and a write changes no output and no readback.
- R5: Address 0x07 is write-only. A write appears on `cfg_key` one cycle after the strobe, and a read returns 0x00.
- R6: `param_a` (12 bits, reset 0x3C5) takes bits 11:8 from bits 3:0 of address 0x02 and bits 7:0 from address 0x03. A write to 0x02 leaves `param_a` unchanged. A write to 0x03 directly after a write to 0x02 updates all 12 bits one cycle after the strobe.
- R7: `param_b` (24 bits, reset 0x0A0B0C) takes bits 23:16 from 0x04, bits 15:8 from 0x05 and bits 7:0 from 0x06. It changes only when 0x04, 0x05 and 0x06 are written in that order with no other register write between them, and then all 24 bits change one cycle after the 0x06 strobe.
- R8: A register write to any other address, or a skipped or repeated byte, while a wide value is partly staged discards the staged bytes. A later final-byte write alone leaves the exported value unchanged.
- R9: A read of a wide-value address returns the committed byte, never a staged one. Bits 7:4 of address 0x02 read as zero.
- R10: `rdata` is loaded one cycle after a `byte_rd` strobe and holds between reads. Unmapped addresses read 0x00, and writes to them are ignored.
- R11: Byte strobes after `bus_stop` and before the next `bus_start` are ignored. A synchronous `rst` returns every output to its reset value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_start | input | 1 | Transaction start strobe |
| bus_stop | input | 1 | Transaction stop strobe |
| byte_wr | input | 1 | Received byte strobe |
| byte_rd | input | 1 | Byte read request strobe |
| wdata | input | 8 | Received byte |
| stat_in | input | 8 | Live status presented at address 0x01 |
| rdata | output | 8 | Read byte, loaded on a read strobe |
| cfg_ctrl | output | 8 | Committed control byte |
| cfg_key | output | 8 | Last written key byte |
| param_a | output | 12 | Committed 12-bit value |
| param_b | output | 24 | Committed 24-bit value |

## Verification
Every result of this block comes out through one register stage. The pointer, `cfg_ctrl`, `cfg_key`, a committed wide value and `rdata` all change at the first rising edge after the strobe that causes them. The bench drives each strobe for exactly one cycle, starting at a falling edge. It samples outputs at the next falling edge, half a cycle after the change is due. Wide values are sampled after each staged byte to confirm they have not moved yet, and again after the final byte to confirm the single-step commit.

// File: rtl/rb_pkg.sv
package rb_pkg;
   localparam int unsigned RB_AW = 8;
   localparam int unsigned RB_DW = 8;

   localparam logic [RB_AW-1:0] ADDR_CTRL = 8'h00;
   localparam logic [RB_AW-1:0] ADDR_STAT = 8'h01;
   localparam logic [RB_AW-1:0] ADDR_PA   = 8'h02;
   localparam logic [RB_AW-1:0] ADDR_PB   = 8'h04;
   localparam logic [RB_AW-1:0] ADDR_KEY  = 8'h07;

   localparam int unsigned PA_WIDTH = 12;
   localparam int unsigned PB_WIDTH = 24;
   localparam logic [PA_WIDTH-1:0] PA_RESET = 12'h3C5;
   localparam logic [PB_WIDTH-1:0] PB_RESET = 24'h0A0B0C;
endpackage

// File: rtl/rb_ptr.sv
module rb_ptr #(
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          bus_start,
   input  logic          bus_stop,
   input  logic          byte_wr,
   input  logic          byte_rd,
   input  logic [AW-1:0] wdata_addr,
   output logic [AW-1:0] ptr,
   output logic          addr_wr,
   output logic          data_wr,
   output logic          data_rd,
   output logic          active
);
   logic addr_phase;
   logic quiet;

   // start and stop strobes take precedence over a byte in the same cycle
   assign quiet   = bus_start | bus_stop | ~active;
   assign addr_wr = ~quiet & addr_phase & byte_wr;
   assign data_wr = ~quiet & ~addr_phase & byte_wr;
   assign data_rd = ~quiet & byte_rd;

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr        <= '0;
         active     <= 1'b0;
         addr_phase <= 1'b0;
      end else begin
         if (bus_start) begin
            active     <= 1'b1;
            addr_phase <= 1'b1;
         end else if (bus_stop) begin
            active     <= 1'b0;
            addr_phase <= 1'b0;
         end else if (addr_wr) begin
            ptr        <= wdata_addr;
            addr_phase <= 1'b0;
         end else if (data_wr || data_rd) begin
            ptr <= ptr + AW'(1);
         end
      end
   end
endmodule

// File: rtl/rb_wide_param.sv
module rb_wide_param #(
   parameter int unsigned AW     = 8,
   parameter int unsigned DW     = 8,
   parameter int unsigned NBYTES = 2,
   parameter int unsigned WIDTH  = 12,
   parameter logic [AW-1:0]    BASE    = '0,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [WIDTH-1:0] live,
   output logic [DW-1:0]    rd_byte
);
   localparam int unsigned SHW      = (NBYTES - 1) * DW;
   localparam int unsigned FULLW    = NBYTES * DW;
   localparam int unsigned TOP_BITS = WIDTH - SHW;
   localparam int unsigned PADW     = FULLW - WIDTH;
   localparam int unsigned EW       = $clog2(NBYTES) + 1;
   localparam logic [DW-1:0] TOP_MASK = DW'((2 ** TOP_BITS) - 1);

   if (NBYTES < 2) begin : g_bad_nbytes
      $error("rb_wide_param: NBYTES must be at least 2");
   end
   if (WIDTH <= SHW || WIDTH > FULLW) begin : g_bad_width
      $error("rb_wide_param: WIDTH does not fit NBYTES bytes");
   end

   logic [SHW-1:0]   shadow;
   logic [EW-1:0]    expect_idx;
   logic [AW-1:0]    idx;
   logic             in_range;
   logic [FULLW-1:0] full;
   logic [FULLW-1:0] padded;

   assign idx      = addr - BASE;
   assign in_range = (int'(idx) < int'(NBYTES));
   assign full     = {shadow, wdata};

   if (PADW == 0) begin : g_nopad
      assign padded = live;
   end else begin : g_pad
      assign padded = {{PADW{1'b0}}, live};
   end

   always_comb begin
      rd_byte = '0;
      if (in_range)
         rd_byte = padded[(int'(NBYTES) - 1 - int'(idx)) * int'(DW) +: DW];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         live       <= RST_VAL;
         shadow     <= '0;
         expect_idx <= '0;
      end else if (wr_en) begin
         if (!in_range) begin
            expect_idx <= '0;
         end else if (idx == '0) begin
            shadow[SHW-1 -: DW] <= wdata & TOP_MASK;
            expect_idx          <= EW'(1);
         end else if (expect_idx != '0 && int'(idx) == int'(expect_idx)) begin
            if (int'(idx) == int'(NBYTES) - 1) begin
               live       <= full[WIDTH-1:0];
               expect_idx <= '0;
            end else begin
               shadow[(int'(NBYTES) - 2 - int'(idx)) * int'(DW) +: DW] <= wdata;
               expect_idx <= expect_idx + EW'(1);
            end
         end else begin
            expect_idx <= '0;
         end
      end
   end
endmodule

// File: rtl/regbank_atomic.sv
module regbank_atomic
   import rb_pkg::*;
#(
   parameter int unsigned AW = RB_AW,
   parameter int unsigned DW = RB_DW,
   parameter int unsigned A_WIDTH = PA_WIDTH,
   parameter int unsigned B_WIDTH = PB_WIDTH,
   parameter logic [A_WIDTH-1:0] A_RESET = PA_RESET,
   parameter logic [B_WIDTH-1:0] B_RESET = PB_RESET
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bus_start,
   input  logic               bus_stop,
   input  logic               byte_wr,
   input  logic               byte_rd,
   input  logic [DW-1:0]      wdata,
   input  logic [DW-1:0]      stat_in,
   output logic [DW-1:0]      rdata,
   output logic [DW-1:0]      cfg_ctrl,
   output logic [DW-1:0]      cfg_key,
   output logic [A_WIDTH-1:0] param_a,
   output logic [B_WIDTH-1:0] param_b
);
   localparam int unsigned A_BYTES = (A_WIDTH + DW - 1) / DW;
   localparam int unsigned B_BYTES = (B_WIDTH + DW - 1) / DW;

   if (AW != DW) begin : g_bad_aw
      $error("regbank_atomic: pointer is loaded from one data byte, AW must equal DW");
   end

   logic [AW-1:0] ptr;
   logic          addr_wr;
   logic          data_wr;
   logic          data_rd;
   logic          active;
   logic [DW-1:0] a_rd;
   logic [DW-1:0] b_rd;
   logic [DW-1:0] rd_mux;

   rb_ptr #(.AW(AW)) u_ptr (
      .clk        (clk),
      .rst        (rst),
      .bus_start  (bus_start),
      .bus_stop   (bus_stop),
      .byte_wr    (byte_wr),
      .byte_rd    (byte_rd),
      .wdata_addr (wdata),
      .ptr        (ptr),
      .addr_wr    (addr_wr),
      .data_wr    (data_wr),
      .data_rd    (data_rd),
      .active     (active)
   );

   rb_wide_param #(
      .AW(AW), .DW(DW), .NBYTES(A_BYTES), .WIDTH(A_WIDTH),
      .BASE(ADDR_PA), .RST_VAL(A_RESET)
   ) u_pa (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (data_wr),
      .addr    (ptr),
      .wdata   (wdata),
      .live    (param_a),
      .rd_byte (a_rd)
   );

   rb_wide_param #(
      .AW(AW), .DW(DW), .NBYTES(B_BYTES), .WIDTH(B_WIDTH),
      .BASE(ADDR_PB), .RST_VAL(B_RESET)
   ) u_pb (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (data_wr),
      .addr    (ptr),
      .wdata   (wdata),
      .live    (param_b),
      .rd_byte (b_rd)
   );

   // write-only key contributes nothing to the read path
   always_comb begin
      rd_mux = a_rd | b_rd;
      if (ptr == ADDR_CTRL) rd_mux = cfg_ctrl;
      if (ptr == ADDR_STAT) rd_mux = stat_in;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_ctrl <= '0;
         cfg_key  <= '0;
         rdata    <= '0;
      end else begin
         if (data_wr && ptr == ADDR_CTRL) cfg_ctrl <= wdata;
         if (data_wr && ptr == ADDR_KEY)  cfg_key  <= wdata;
         if (data_rd)                     rdata    <= rd_mux;
      end
   end
endmodule

// File: rtl/regbank_atomic_chk.sv
module regbank_atomic_chk
   import rb_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [7:0]  ptr,
   input logic        addr_wr,
   input logic        data_wr,
   input logic        data_rd,
   input logic [7:0]  wdata,
   input logic [7:0]  rdata,
   input logic [7:0]  cfg_ctrl,
   input logic [7:0]  cfg_key,
   input logic [11:0] param_a,
   input logic [23:0] param_b
);
   // R1
   ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
      addr_wr |=> ptr == $past(wdata));

   // R2
   ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
      (data_wr || data_rd) |=> ptr == 8'($past(ptr) + 8'd1));

   // R3
   ctrl_src_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(cfg_ctrl) |-> $past(data_wr && ptr == ADDR_CTRL));

   // R5
   key_src_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(cfg_key) |-> $past(data_wr && ptr == ADDR_KEY));

   // R6
   pa_commit_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(param_a) |-> $past(data_wr && ptr == 8'h03));

   // R7
   pb_commit_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(param_b) |-> $past(data_wr && ptr == 8'h06));

   // R10
   rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(rdata) |-> $past(data_rd));
endmodule

bind regbank_atomic regbank_atomic_chk u_chk (
   .clk      (clk),
   .rst      (rst),
   .ptr      (ptr),
   .addr_wr  (addr_wr),
   .data_wr  (data_wr),
   .data_rd  (data_rd),
   .wdata    (wdata),
   .rdata    (rdata),
   .cfg_ctrl (cfg_ctrl),
   .cfg_key  (cfg_key),
   .param_a  (param_a),
   .param_b  (param_b)
);

// File: tb/regbank_atomic_tb.sv
module regbank_atomic_tb_top;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        bus_start = 1'b0;
   logic        bus_stop = 1'b0;
   logic        byte_wr = 1'b0;
   logic        byte_rd = 1'b0;
   logic [7:0]  wdata = '0;
   logic [7:0]  stat_in = 8'hC3;
   logic [7:0]  rdata;
   logic [7:0]  cfg_ctrl;
   logic [7:0]  cfg_key;
   logic [11:0] param_a;
   logic [23:0] param_b;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regbank_atomic dut_i (
      .clk(clk), .rst(rst), .bus_start(bus_start), .bus_stop(bus_stop),
      .byte_wr(byte_wr), .byte_rd(byte_rd), .wdata(wdata), .stat_in(stat_in),
      .rdata(rdata), .cfg_ctrl(cfg_ctrl), .cfg_key(cfg_key),
      .param_a(param_a), .param_b(param_b)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // every strobe is one cycle wide, launched and retired at falling edges
   task automatic pulse_start();
      @(negedge clk); bus_start = 1'b1;
      @(negedge clk); bus_start = 1'b0;
   endtask

   task automatic pulse_stop();
      @(negedge clk); bus_stop = 1'b1;
      @(negedge clk); bus_stop = 1'b0;
   endtask

   task automatic put(logic [7:0] b);
      @(negedge clk); byte_wr = 1'b1; wdata = b;
      @(negedge clk); byte_wr = 1'b0;
   endtask

   task automatic get(output logic [7:0] b);
      @(negedge clk); byte_rd = 1'b1;
      @(negedge clk); byte_rd = 1'b0; b = rdata;
   endtask

   task automatic t_reset();
      chk("R11 reset cfg_ctrl", 32'(cfg_ctrl), 32'h00);
      chk("R11 reset cfg_key", 32'(cfg_key), 32'h00);
      chk("R6 reset param_a", 32'(param_a), 32'h3C5);
      chk("R7 reset param_b", 32'(param_b), 32'h0A0B0C);
      chk("R10 reset rdata", 32'(rdata), 32'h00);
   endtask

   task automatic t_ctrl();
      logic [7:0] r;
      pulse_start(); put(8'h00); put(8'h5A);
      chk("R3 ctrl write", 32'(cfg_ctrl), 32'h5A);
      pulse_stop();
      pulse_start(); put(8'h00); get(r);
      chk("R1 R3 ctrl readback", 32'(r), 32'h5A);
      pulse_stop();
   endtask

   task automatic t_param_a();
      logic [7:0] r;
      pulse_start(); put(8'h02); put(8'hF7);
      chk("R6 staged byte hidden", 32'(param_a), 32'h3C5);
      put(8'h9E);
      chk("R6 atomic commit", 32'(param_a), 32'h79E);
      pulse_stop();
      pulse_start(); put(8'h02); get(r);
      chk("R9 upper bits zero", 32'(r), 32'h07);
      get(r);
      chk("R9 R2 low byte readback", 32'(r), 32'h9E);
      pulse_stop();
   endtask

   task automatic t_param_b();
      logic [7:0] r;
      pulse_start(); put(8'h04); put(8'h11);
      chk("R7 first byte hidden", 32'(param_b), 32'h0A0B0C);
      put(8'h22);
      chk("R7 second byte hidden", 32'(param_b), 32'h0A0B0C);
      put(8'h33);
      chk("R7 commit", 32'(param_b), 32'h112233);
      pulse_stop();
      pulse_start(); put(8'h04); put(8'h99); pulse_stop();
      pulse_start(); put(8'h04); get(r);
      chk("R9 committed not staged", 32'(r), 32'h11);
      pulse_stop();
   endtask

   task automatic t_abort();
      pulse_start(); put(8'h02); put(8'h05); pulse_stop();
      pulse_start(); put(8'h00); put(8'h44); pulse_stop();
      pulse_start(); put(8'h03); put(8'h66); pulse_stop();
      chk("R8 interrupted sequence", 32'(param_a), 32'h79E);
      chk("R8 other write applied", 32'(cfg_ctrl), 32'h44);
      pulse_start(); put(8'h03); put(8'h77); pulse_stop();
      chk("R8 final byte alone", 32'(param_a), 32'h79E);
      pulse_start(); put(8'h04); put(8'h5A); pulse_stop();
      pulse_start(); put(8'h06); put(8'h5B); pulse_stop();
      chk("R8 skipped byte", 32'(param_b), 32'h112233);
   endtask

   task automatic t_status();
      logic [7:0] r;
      pulse_start(); put(8'h01); get(r);
      chk("R4 status read", 32'(r), 32'hC3);
      pulse_stop();
      pulse_start(); put(8'h01); put(8'hFF); pulse_stop();
      pulse_start(); put(8'h01); get(r);
      chk("R4 write ignored readback", 32'(r), 32'hC3);
      pulse_stop();
      chk("R4 write ignored ctrl", 32'(cfg_ctrl), 32'h44);
   endtask

   task automatic t_key();
      logic [7:0] r;
      pulse_start(); put(8'h07); put(8'h9D);
      chk("R5 key write", 32'(cfg_key), 32'h9D);
      pulse_stop();
      pulse_start(); put(8'h07); get(r);
      chk("R5 key reads zero", 32'(r), 32'h00);
      pulse_stop();
   endtask

   task automatic t_wrap();
      logic [7:0] r;
      pulse_start(); put(8'hFE); put(8'h12); put(8'h34); put(8'h66);
      chk("R2 wrap to 0x00", 32'(cfg_ctrl), 32'h66);
      pulse_stop();
      pulse_start(); put(8'hFE); get(r);
      chk("R10 unmapped reads zero", 32'(r), 32'h00);
      get(r); get(r);
      chk("R2 R10 wrapped read", 32'(r), 32'h66);
      repeat (5) @(negedge clk);
      chk("R10 rdata holds", 32'(rdata), 32'h66);
      pulse_stop();
   endtask

   task automatic t_idle_and_reset();
      put(8'h00); put(8'h11);
      chk("R11 bytes outside transaction", 32'(cfg_ctrl), 32'h66);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      chk("R11 reset ctrl", 32'(cfg_ctrl), 32'h00);
      chk("R11 reset param_a", 32'(param_a), 32'h3C5);
      chk("R11 reset param_b", 32'(param_b), 32'h0A0B0C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_param_a();
      t_param_b();
      t_abort();
      t_status();
      t_key();
      t_wrap();
      t_idle_and_reset();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule